// File: doc/BRIEF.md
# Pulse-and-Verify Word Programming Sequencer

This controller burns a range of 16-bit words into an erasable, one-time-writable memory array. The array starts erased, with every bit set to 1. Programming can only clear bits to 0.

For each word in the range, the sequencer first reads the word back. It refuses any word whose target value needs a 0 turned back into a 1. Otherwise it applies fixed-width chip-enable pulses with the program voltage requested. After every pulse it reads the full word back. It moves to the next address only when the read-back matches the target. A word that still mismatches after the allowed number of pulses aborts the run. No extra pulse is given once a word verifies.

When the last word verifies, the program voltage is dropped and the bus is switched to 16-bit reads. Every word in the range is then read twice, first at the higher supply level and then at the lower one. Any mismatch in either pass ends the run with a failure code and the address involved.

All timing counts a one-microsecond tick input. Every wait therefore ends on a tick, and the pulse and setup intervals are whole multiples of that tick. The target data comes from a source port that the sequencer addresses itself.

Top module: `prog_pulse_sequencer`

## Requirements
- R1: Out of reset and whenever idle, `busy`, `done`, `fail`, `vpp_req`, `vcc_low` and `word_sel` are low, and `ce_n` and `oe_n` are high.
- R2: `mem_addr` and `mem_wdata` stay unchanged for at least SETUP_TICKS ticks before every fall of `ce_n`, and for at least SETUP_TICKS ticks after every rise of `ce_n`.
- R3: Every program pulse holds `ce_n` low for exactly PULSE_TICKS ticks, with `oe_n` high and `vpp_req` high for the whole pulse.
- R4: After each pulse, a verify read follows with `ce_n` high, `oe_n` low and `vpp_req` still high. It compares all 16 bits of `rd_data` with the target. A match moves on to the next address, so every word in the range ends equal to its target.
- R5: The pulse count restarts at zero for each word. A word that first verifies on its MAX_PULSES-th pulse is accepted. A word whose verify fails after the MAX_PULSES-th pulse ends the run with `fail` high, `fail_code` = 0 and `fail_addr` set to that word, after exactly MAX_PULSES pulses on it.
- R6: Before the first pulse on a word, the word is read back. If the target has a 1 in any bit where the read shows 0, the run ends with `fail_code` = 3 and `fail_addr` set to that word. That word gets no pulse, and no later word is touched.
- R7: After the last word verifies, `vpp_req` goes low and `word_sel` goes high. Every address from `first_addr` to `last_addr` is read once, in ascending order, with `vcc_low` = 0. The same addresses are then read once more with `vcc_low` = 1.
- R8: A mismatch in the final check ends the run with `fail` high and `fail_addr` set to the word. `fail_code` is 1 if the mismatch came in the higher-supply pass and 2 if it came in the lower-supply pass. No further reads follow.
- R9: `busy` is high from the cycle after `start` until the run ends. `done` goes high only when both check passes are clean. `done` and `fail` are never high together, and each holds until the next `start` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_us | input | 1 | One-cycle pulse, once per microsecond |
| start | input | 1 | Begin a run (sampled while idle) |
| first_addr | input | AW | First word address of the range |
| last_addr | input | AW | Last word address of the range |
| src_addr | output | AW | Address presented to the data source |
| src_data | input | DW | Target word for `src_addr` |
| rd_data | input | DW | Word read back from the memory |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Data driven to the memory for programming |
| ce_n | output | 1 | Chip enable, low during a program pulse |
| oe_n | output | 1 | Output enable, low during reads |
| vpp_req | output | 1 | Request for program voltage |
| vcc_low | output | 1 | Supply select: 0 higher level, 1 lower level |
| word_sel | output | 1 | 16-bit read width selected for the final check |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished with every check clean |
| fail | output | 1 | Run aborted |
| fail_addr | output | AW | Word that caused the abort |
| fail_code | output | 2 | 0 pulses exhausted, 1 high-pass check, 2 low-pass check, 3 unprogrammable |

## Verification
The assertions take several things for granted. `tick_us` is a single-cycle pulse with at least one idle cycle between pulses. `src_data` is a pure function of `src_addr`. `rd_data` reflects the addressed word by the next clock edge. `start` arrives only while idle, and `first_addr` never exceeds `last_addr`.

The bench stays within these limits. It raises the tick on every second cycle and serves the source and the memory combinationally from arrays. It issues `start` only after the previous run has ended. Its behavioural memory clears bits only when a pulse ends, and only after a per-word number of pulses. It can also flip a bit at one chosen address when that address is read at a chosen supply level.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_VPP_UP,
        ST_ADDR,
        ST_PULSE,
        ST_VERIFY,
        ST_CK_ADDR,
        ST_CK_READ
    } seq_state_e;

    typedef enum logic [1:0] {
        FC_PULSES  = 2'd0,
        FC_CHK_HI  = 2'd1,
        FC_CHK_LO  = 2'd2,
        FC_BLOCKED = 2'd3
    } fail_code_e;

endpackage

// File: rtl/prog_tick_timer.sv
module prog_tick_timer #(
    parameter int TW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          tick,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear)
            cnt_d = '0;
        else if (tick)
            cnt_d = cnt_q + TW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign expired = tick && (cnt_q == limit - TW'(1));

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (limit != '0) |-> (cnt_q < limit)); // R3

endmodule

// File: rtl/prog_word_check.sv
module prog_word_check #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] want,
    input  logic [DW-1:0] got,
    output logic          match,
    output logic          blocked
);
    assign match   = (want == got);
    assign blocked = |(want & ~got);
endmodule

// File: rtl/prog_pulse_sequencer.sv
module prog_pulse_sequencer
    import prog_seq_pkg::*;
#(
    parameter int AW          = 4,
    parameter int DW          = 16,
    parameter int PULSE_TICKS = 50,
    parameter int SETUP_TICKS = 2,
    parameter int MAX_PULSES  = 25
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_us,
    input  logic          start,
    input  logic [AW-1:0] first_addr,
    input  logic [AW-1:0] last_addr,
    output logic [AW-1:0] src_addr,
    input  logic [DW-1:0] src_data,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          ce_n,
    output logic          oe_n,
    output logic          vpp_req,
    output logic          vcc_low,
    output logic          word_sel,
    output logic          busy,
    output logic          done,
    output logic          fail,
    output logic [AW-1:0] fail_addr,
    output logic [1:0]    fail_code
);
    localparam int LONGEST = (PULSE_TICKS > SETUP_TICKS + 1) ? PULSE_TICKS : SETUP_TICKS + 1;
    localparam int TW      = $clog2(LONGEST + 1);
    localparam int CW      = $clog2(MAX_PULSES + 1);

    typedef struct packed {
        seq_state_e    st;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [CW-1:0] pcnt;
        logic          pass;
        logic          busy;
        logic          done;
        logic          fail;
        logic [AW-1:0] faddr;
        logic [1:0]    fcode;
    } seq_t;

    seq_t          r_d, r_q;
    logic          timer_clear;
    logic          expired;
    logic [TW-1:0] limit;
    logic          match;
    logic          blocked;

    prog_tick_timer #(.TW(TW)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (timer_clear),
        .tick    (tick_us),
        .limit   (limit),
        .expired (expired)
    );

    prog_word_check #(.DW(DW)) i_check (
        .want    (r_q.data),
        .got     (rd_data),
        .match   (match),
        .blocked (blocked)
    );

    always_comb begin
        unique case (r_q.st)
            ST_VPP_UP, ST_ADDR:   limit = TW'(SETUP_TICKS + 1);
            ST_PULSE:             limit = TW'(PULSE_TICKS);
            ST_VERIFY, ST_CK_READ: limit = TW'(SETUP_TICKS);
            default:              limit = TW'(1);
        endcase
    end

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st    = ST_VPP_UP;
                    r_d.addr  = first_addr;
                    r_d.pcnt  = '0;
                    r_d.pass  = 1'b0;
                    r_d.busy  = 1'b1;
                    r_d.done  = 1'b0;
                    r_d.fail  = 1'b0;
                    r_d.faddr = '0;
                    r_d.fcode = '0;
                end
            end
            ST_VPP_UP: begin
                if (expired)
                    r_d.st = ST_ADDR;
            end
            ST_ADDR: begin
                r_d.data = src_data;
                if (expired) begin
                    if (blocked) begin
                        r_d.st    = ST_IDLE;
                        r_d.busy  = 1'b0;
                        r_d.fail  = 1'b1;
                        r_d.faddr = r_q.addr;
                        r_d.fcode = FC_BLOCKED;
                    end else begin
                        r_d.st   = ST_PULSE;
                        r_d.pcnt = '0;
                    end
                end
            end
            ST_PULSE: begin
                if (expired)
                    r_d.st = ST_VERIFY;
            end
            ST_VERIFY: begin
                if (expired) begin
                    if (match) begin
                        if (r_q.addr == last_addr) begin
                            r_d.st   = ST_CK_ADDR;
                            r_d.addr = first_addr;
                            r_d.pass = 1'b0;
                        end else begin
                            r_d.st   = ST_ADDR;
                            r_d.addr = r_q.addr + AW'(1);
                        end
                    end else if (r_q.pcnt == CW'(MAX_PULSES - 1)) begin
                        r_d.st    = ST_IDLE;
                        r_d.busy  = 1'b0;
                        r_d.fail  = 1'b1;
                        r_d.faddr = r_q.addr;
                        r_d.fcode = FC_PULSES;
                    end else begin
                        r_d.st   = ST_PULSE;
                        r_d.pcnt = r_q.pcnt + CW'(1);
                    end
                end
            end
            ST_CK_ADDR: begin
                r_d.data = src_data;
                if (expired)
                    r_d.st = ST_CK_READ;
            end
            ST_CK_READ: begin
                if (expired) begin
                    if (!match) begin
                        r_d.st    = ST_IDLE;
                        r_d.busy  = 1'b0;
                        r_d.fail  = 1'b1;
                        r_d.faddr = r_q.addr;
                        r_d.fcode = r_q.pass ? FC_CHK_LO : FC_CHK_HI;
                    end else if (r_q.addr != last_addr) begin
                        r_d.st   = ST_CK_ADDR;
                        r_d.addr = r_q.addr + AW'(1);
                    end else if (!r_q.pass) begin
                        r_d.st   = ST_CK_ADDR;
                        r_d.addr = first_addr;
                        r_d.pass = 1'b1;
                    end else begin
                        r_d.st   = ST_IDLE;
                        r_d.busy = 1'b0;
                        r_d.done = 1'b1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
        timer_clear = (r_d.st != r_q.st) || (r_q.st == ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, addr: '0, data: '0, pcnt: '0, pass: 1'b0,
                     busy: 1'b0, done: 1'b0, fail: 1'b0, faddr: '0, fcode: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign src_addr  = r_q.addr;
    assign mem_addr  = r_q.addr;
    assign mem_wdata = r_q.data;
    assign ce_n      = (r_q.st != ST_PULSE);
    assign oe_n      = !((r_q.st == ST_ADDR) || (r_q.st == ST_VERIFY) || (r_q.st == ST_CK_READ));
    assign vpp_req   = (r_q.st == ST_VPP_UP) || (r_q.st == ST_ADDR) ||
                       (r_q.st == ST_PULSE) || (r_q.st == ST_VERIFY);
    assign word_sel  = (r_q.st == ST_CK_ADDR) || (r_q.st == ST_CK_READ);
    assign vcc_low   = word_sel && r_q.pass;
    assign busy      = r_q.busy;
    assign done      = r_q.done;
    assign fail      = r_q.fail;
    assign fail_addr = r_q.faddr;
    assign fail_code = r_q.fcode;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ce_n && oe_n && !vpp_req && !word_sel)); // R1
    AST_PULSE_HOLDS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && $past(!ce_n)) |-> ($stable(mem_addr) && $stable(mem_wdata))); // R2
    AST_PULSE_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_n |-> (oe_n && vpp_req)); // R3
    AST_VERIFY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ce_n) |-> (!oe_n && vpp_req)); // R4
    AST_PULSE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.pcnt < CW'(MAX_PULSES)); // R5
    AST_CHECK_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
        vcc_low |-> (!vpp_req && word_sel && ce_n)); // R7
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail)); // R9
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R9

endmodule

// File: tb/test_prog_pulse_sequencer.sv
module test_prog_pulse_sequencer;
    localparam int AW    = 4;
    localparam int DW    = 16;
    localparam int PT    = 50;
    localparam int ST    = 2;
    localparam int MAXP  = 25;
    localparam int TD    = 2;
    localparam int NW    = 1 << AW;
    localparam int WDOG  = 60000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_us = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] first_addr = '0, last_addr = '0;
    logic [AW-1:0] src_addr, mem_addr, fail_addr;
    logic [DW-1:0] src_data, rd_data, mem_wdata;
    logic          ce_n, oe_n, vpp_req, vcc_low, word_sel, busy, done, fail;
    logic [1:0]    fail_code;

    logic [DW-1:0] mem [NW];
    logic [DW-1:0] tgt [NW];
    int need [NW];
    int pulses [NW];
    int rdh [NW];
    int rdl [NW];
    int weak_hi = -1, weak_lo = -1;

    int n_tests = 0, n_fail = 0;
    int v_setup = 0, v_hold = 0, v_width = 0, v_oe = 0, v_mode = 0;
    int since_chg = 1000, since_rise = 1000, low_len = 0;
    logic          pce_n = 1'b1, poe_n = 1'b1;
    logic [AW-1:0] paddr = '0;
    logic [DW-1:0] pw = '0;

    always #5 clk = ~clk;

    prog_pulse_sequencer #(.AW(AW), .DW(DW), .PULSE_TICKS(PT), .SETUP_TICKS(ST),
                           .MAX_PULSES(MAXP)) i_prog_pulse_sequencer (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .start(start),
        .first_addr(first_addr), .last_addr(last_addr),
        .src_addr(src_addr), .src_data(src_data), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .ce_n(ce_n), .oe_n(oe_n),
        .vpp_req(vpp_req), .vcc_low(vcc_low), .word_sel(word_sel),
        .busy(busy), .done(done), .fail(fail),
        .fail_addr(fail_addr), .fail_code(fail_code)
    );

    always_comb begin
        src_data = tgt[src_addr];
        rd_data  = mem[mem_addr];
        if (!vpp_req && word_sel) begin
            if (!vcc_low && int'(mem_addr) == weak_hi) rd_data = rd_data ^ 16'h0001;
            if (vcc_low && int'(mem_addr) == weak_lo)  rd_data = rd_data ^ 16'h0001;
        end
    end

    always @(negedge clk) begin
        tick_us <= ~tick_us;
        if (rst_n) begin
            if (!pce_n && ce_n) begin
                since_rise = 0;
                if (low_len != PT * TD) v_width++;
                if (vpp_req) begin
                    pulses[mem_addr]++;
                    if (pulses[mem_addr] >= need[mem_addr])
                        mem[mem_addr] = mem[mem_addr] & mem_wdata;
                end
            end else begin
                since_rise++;
            end
            if (mem_addr != paddr || mem_wdata != pw) begin
                if (since_rise < ST * TD) v_hold++;
                since_chg = 0;
            end else begin
                since_chg++;
            end
            if (pce_n && !ce_n) begin
                if (since_chg < ST * TD) v_setup++;
                low_len = 0;
            end
            if (!ce_n) begin
                low_len++;
                if (!oe_n || !vpp_req) v_oe++;
            end
            if (poe_n && !oe_n && !vpp_req) begin
                if (!word_sel) v_mode++;
                if (vcc_low) rdl[mem_addr]++;
                else         rdh[mem_addr]++;
            end
        end
        pce_n = ce_n;
        poe_n = oe_n;
        paddr = mem_addr;
        pw    = mem_wdata;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic init_mem();
        for (int a = 0; a < NW; a++) begin
            mem[a]    = 16'hFFFF;
            tgt[a]    = DW'((a * 16'h1357) ^ 16'hA5C3);
            need[a]   = (a * 7) % 6 + 1;
            pulses[a] = 0;
            rdh[a]    = 0;
            rdl[a]    = 0;
        end
        weak_hi = -1;
        weak_lo = -1;
        v_setup = 0; v_hold = 0; v_width = 0; v_oe = 0; v_mode = 0;
    endtask

    task automatic run(input int fa, input int la);
        int cyc;
        @(negedge clk);
        first_addr = AW'(fa);
        last_addr  = AW'(la);
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R9", "busy after start", int'(busy), 1);
        check("R9", "flags cleared by start", int'(done | fail), 0);
        cyc = 0;
        while (busy && cyc < WDOG) begin
            @(negedge clk);
            cyc++;
        end
        if (busy) check("R9", "watchdog expired", 1, 0);
        repeat (5) @(negedge clk);
    endtask

    task automatic timing_ok();
        check("R2", "setup violations", v_setup, 0);
        check("R2", "hold violations", v_hold, 0);
        check("R3", "pulse width violations", v_width, 0);
        check("R3", "oe/vpp during pulse", v_oe, 0);
        check("R7", "check read width mode", v_mode, 0);
    endtask

    initial begin
        init_mem();
        repeat (3) @(negedge clk);
        check("R1", "busy in reset", int'(busy), 0);
        check("R1", "ce_n in reset", int'(ce_n), 1);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1", "idle busy/done/fail", int'({busy, done, fail}), 0);
        check("R1", "idle ce_n/oe_n", int'({ce_n, oe_n}), 3);
        check("R1", "idle vpp/vcc_low/word_sel", int'({vpp_req, vcc_low, word_sel}), 0);

        // full sweep, varied pulse needs
        init_mem();
        run(0, NW - 1);
        check("R9", "sweep done", int'(done), 1);
        check("R9", "sweep fail", int'(fail), 0);
        for (int a = 0; a < NW; a++) begin
            check("R4", $sformatf("word %0d content", a), int'(mem[a]), int'(tgt[a]));
            check("R5", $sformatf("word %0d pulses", a), pulses[a], need[a]);
            check("R7", $sformatf("word %0d high reads", a), rdh[a], 1);
            check("R7", $sformatf("word %0d low reads", a), rdl[a], 1);
        end
        timing_ok();
        check("R1", "idle after sweep", int'({ce_n, oe_n, vpp_req}), 6);

        // exactly MAX pulses accepted
        init_mem();
        need[2] = MAXP;
        run(2, 2);
        check("R5", "limit word done", int'(done), 1);
        check("R5", "limit word pulses", pulses[2], MAXP);
        check("R4", "limit word content", int'(mem[2]), int'(tgt[2]));
        timing_ok();

        // one more than MAX: abort
        init_mem();
        need[2] = MAXP + 1;
        run(1, 3);
        check("R5", "exhaust fail", int'(fail), 1);
        check("R5", "exhaust code", int'(fail_code), 0);
        check("R5", "exhaust addr", int'(fail_addr), 2);
        check("R5", "exhaust pulses", pulses[2], MAXP);
        check("R5", "next word untouched", pulses[3], 0);
        check("R9", "exhaust not done", int'(done), 0);

        // unprogrammable word
        init_mem();
        mem[3] = 16'hFF00;
        tgt[3] = 16'h0F0F;
        run(0, 5);
        check("R6", "blocked fail", int'(fail), 1);
        check("R6", "blocked code", int'(fail_code), 3);
        check("R6", "blocked addr", int'(fail_addr), 3);
        check("R6", "blocked no pulse", pulses[3], 0);
        check("R6", "later word untouched", pulses[4], 0);
        check("R6", "earlier word pulses", pulses[2], need[2]);
        check("R6", "blocked word unchanged", int'(mem[3]), 16'hFF00);

        // weak at low supply
        init_mem();
        weak_lo = 2;
        run(0, 3);
        check("R8", "low pass fail", int'(fail), 1);
        check("R8", "low pass code", int'(fail_code), 2);
        check("R8", "low pass addr", int'(fail_addr), 2);
        check("R7", "high pass complete", rdh[0] + rdh[1] + rdh[2] + rdh[3], 4);
        check("R7", "low reads up to failure", rdl[0] + rdl[1] + rdl[2], 3);
        check("R8", "no read after failure", rdl[3], 0);

        // weak at high supply
        init_mem();
        weak_hi = 1;
        run(0, 3);
        check("R8", "high pass fail", int'(fail), 1);
        check("R8", "high pass code", int'(fail_code), 1);
        check("R8", "high pass addr", int'(fail_addr), 1);
        check("R8", "no low pass", rdl[0], 0);
        check("R8", "stop after high fail", rdh[2], 0);

        // restart after failure, single word
        init_mem();
        run(5, 5);
        check("R9", "restart done", int'(done), 1);
        check("R9", "restart fail cleared", int'(fail), 0);
        check("R4", "single word content", int'(mem[5]), int'(tgt[5]));
        check("R7", "single word reads", rdh[5] + rdl[5], 2);
        check("R4", "neighbour untouched", int'(mem[6]), 16'hFFFF);
        repeat (20) @(negedge clk);
        check("R9", "done held", int'(done), 1);
        timing_ok();

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule